// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block collects interrupt requests from PCI devices and turns them into level signals for a legacy sixteen-input interrupt controller. A requesting device presents its device/function address, the interrupt pin it uses (INTA to INTD) and the new level. The router rotates that pin by the device's slot number onto one of four shared interrupt lines. It then stores the level for that line.

Four byte-wide steering registers, one for each shared line, choose which controller input each line drives. A register value below the number of controller inputs selects that input. A larger value leaves the line unconnected. When several lines are steered to the same input, their levels are ORed together. The outputs are registered and recomputed on every clock. A change to a steering register therefore moves an already-active interrupt without a new request from the device.

Top module: `pirq_router`

## Requirements
- R1: The shared line for a request is (pin + device − 1) mod 4. The device number is `req_devfn[7:3]`, and `req_pin` values 0, 1, 2 and 3 stand for INTA, INTB, INTC and INTD.
- R2: Device number 0 wraps around. Pin 0 of device 0 lands on line 3, and pin k of device 0 lands on line (k+3) mod 4.
- R3: Shared line k owns the steering register at configuration offset 0x60+k. A read at that offset returns the last byte written there unchanged, including bit 7. Reads at any other offset return 0, and writes to other offsets leave all four registers unchanged.
- R4: After reset, every steering register reads 0x80, every stored line level is 0 and `ctrl_irq` is all zeros.
- R5: A steering value v below 16 drives controller input v. Any value of 16 or more, including 0x80 and 0xFF, drives no input at all.
- R6: Each bit of `ctrl_irq` is the OR of the stored levels of all shared lines currently steered to it.
- R7: `ctrl_irq` is registered. A steering write or a level request sampled at rising edge N shows on `ctrl_irq` after rising edge N+1, and not before. A steering change moves an active line without any new request.
- R8: A request updates only the stored level of its own shared line. A level of 0 clears that line, and the other three lines keep their levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Interrupt level update strobe |
| req_devfn | input | 8 | Device/function address of the requester |
| req_pin | input | 2 | Interrupt pin of the requester (0 = INTA) |
| req_level | input | 1 | New level for the requester's pin |
| ctrl_irq | output | 16 | Level outputs to the interrupt controller |

## Verification
The rotation is swept over all 32 device numbers and all four pins, with each line steered to a distinct output. This separates an off-by-one rotation from a missing wrap at device 0. The steering value of one active line is swept through 0 to 31, plus 0x80 and 0xFF. This shows the boundary at 16 and shows that bit 7 disables the line. All sixteen level combinations are applied with three lines sharing one input and one line on its own input. This tells a true OR from a last-writer-wins update, and shows that a request leaves the other lines alone. A single timed steering change confirms the one-cycle output register lag.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int LINE_COUNT    = 4;
   localparam int CTRL_INPUTS   = 16;
   localparam int CFG_BYTE_W    = 8;
   localparam int DEVFN_BITS    = 8;
   localparam int DEV_FIELD_LSB = 3;
   localparam logic [7:0] STEER_BASE  = 8'h60;
   localparam logic [7:0] STEER_RESET = 8'h80;
endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
   parameter int NUM_LINES = pirq_pkg::LINE_COUNT,
   parameter int DEVFN_W   = pirq_pkg::DEVFN_BITS,
   parameter int DEV_LSB   = pirq_pkg::DEV_FIELD_LSB,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input  logic [DEVFN_W-1:0] devfn,
   input  logic [LINE_W-1:0]  pin,
   output logic [LINE_W-1:0]  line
);
   localparam bit POW2 = ((1 << LINE_W) == NUM_LINES);

   int unsigned sum;
   always_comb sum = int'(devfn[DEVFN_W-1:DEV_LSB]) + int'(pin) + NUM_LINES - 1;

   generate
      if (POW2) begin : g_mask
         always_comb line = LINE_W'(sum);
      end else begin : g_mod
         always_comb line = LINE_W'(sum % NUM_LINES);
      end
   endgenerate

   always_comb begin
      if (devfn[DEVFN_W-1:DEV_LSB] == '0 && pin == '0)
         assert_wrap_R2: assert (line == LINE_W'(NUM_LINES - 1));
      if (devfn[DEVFN_W-1:DEV_LSB] == 1)
         assert_identity_R1: assert (line == pin);
   end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
   parameter int NUM_LINES            = pirq_pkg::LINE_COUNT,
   parameter int REG_W                = pirq_pkg::CFG_BYTE_W,
   parameter int ADDR_W               = 8,
   parameter logic [ADDR_W-1:0] BASE  = pirq_pkg::STEER_BASE,
   parameter logic [REG_W-1:0] RST_V  = pirq_pkg::STEER_RESET
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [REG_W-1:0]                wdata,
   output logic [REG_W-1:0]                rdata,
   output logic [NUM_LINES-1:0][REG_W-1:0] routes
);
   logic [NUM_LINES-1:0] hit;

   generate
      for (genvar k = 0; k < NUM_LINES; k++) begin : g_reg
         assign hit[k] = (addr == ADDR_W'(int'(BASE) + k));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                routes[k] <= RST_V;
            else if (wr_en && hit[k])  routes[k] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_LINES; k++)
         if (hit[k]) rdata = routes[k];
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(routes));
   assert_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit == '0) |=> $stable(routes));
endmodule

// File: rtl/pirq_level_store.sv
module pirq_level_store #(
   parameter int NUM_LINES = pirq_pkg::LINE_COUNT,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd,
   input  logic [LINE_W-1:0]    line,
   input  logic                 level,
   output logic [NUM_LINES-1:0] levels
);
   generate
      for (genvar k = 0; k < NUM_LINES; k++) begin : g_lvl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            levels[k] <= 1'b0;
            else if (upd && line == LINE_W'(k))    levels[k] <= level;
         end
      end
   endgenerate

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(levels));
   assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> $countones(levels ^ $past(levels)) <= 1);
endmodule

// File: rtl/pirq_steer.sv
module pirq_steer #(
   parameter int NUM_LINES = pirq_pkg::LINE_COUNT,
   parameter int NUM_OUTS  = pirq_pkg::CTRL_INPUTS,
   parameter int REG_W     = pirq_pkg::CFG_BYTE_W
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_LINES-1:0]            levels,
   input  logic [NUM_LINES-1:0][REG_W-1:0] routes,
   output logic [NUM_OUTS-1:0]             irq_out
);
   logic [NUM_OUTS-1:0] next_out;

   generate
      for (genvar j = 0; j < NUM_OUTS; j++) begin : g_out
         logic [NUM_LINES-1:0] src;
         for (genvar k = 0; k < NUM_LINES; k++) begin : g_src
            assign src[k] = levels[k] && (routes[k] == REG_W'(j));
         end
         assign next_out[j] = |src;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out <= '0;
      else        irq_out <= next_out;
   end

   logic all_off;
   always_comb begin
      all_off = 1'b1;
      for (int k = 0; k < NUM_LINES; k++)
         if (int'(routes[k]) < NUM_OUTS) all_off = 1'b0;
   end

   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (levels == '0) |=> (irq_out == '0));
   assert_fanout_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(irq_out) <= $countones($past(levels)));
   assert_unrouted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      all_off |=> (irq_out == '0));
   assert_reset_R4: assert property (@(posedge clk)
      !rst_n |=> (irq_out == '0));
endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
   parameter int NUM_LINES = pirq_pkg::LINE_COUNT,
   parameter int NUM_OUTS  = pirq_pkg::CTRL_INPUTS,
   parameter int REG_W     = pirq_pkg::CFG_BYTE_W,
   parameter int ADDR_W    = 8,
   parameter int DEVFN_W   = pirq_pkg::DEVFN_BITS,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr_en,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic [REG_W-1:0]    cfg_wdata,
   output logic [REG_W-1:0]    cfg_rdata,
   input  logic                req_valid,
   input  logic [DEVFN_W-1:0]  req_devfn,
   input  logic [LINE_W-1:0]   req_pin,
   input  logic                req_level,
   output logic [NUM_OUTS-1:0] ctrl_irq
);
   generate
      if (NUM_LINES < 2) begin : g_bad_lines
         $error("pirq_router: NUM_LINES must be at least 2");
      end
      if (NUM_OUTS > (1 << REG_W)) begin : g_bad_outs
         $error("pirq_router: NUM_OUTS exceeds the steering register range");
      end
      if (DEVFN_W <= pirq_pkg::DEV_FIELD_LSB) begin : g_bad_devfn
         $error("pirq_router: DEVFN_W too narrow for a device field");
      end
   endgenerate

   logic [LINE_W-1:0]              req_line;
   logic [NUM_LINES-1:0]           levels;
   logic [NUM_LINES-1:0][REG_W-1:0] routes;

   pirq_swizzle #(.NUM_LINES(NUM_LINES), .DEVFN_W(DEVFN_W)) u_swz (
      .devfn (req_devfn),
      .pin   (req_pin),
      .line  (req_line)
   );

   pirq_route_regs #(.NUM_LINES(NUM_LINES), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .rdata  (cfg_rdata),
      .routes (routes)
   );

   pirq_level_store #(.NUM_LINES(NUM_LINES)) u_lvl (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (req_valid),
      .line   (req_line),
      .level  (req_level),
      .levels (levels)
   );

   pirq_steer #(.NUM_LINES(NUM_LINES), .NUM_OUTS(NUM_OUTS), .REG_W(REG_W)) u_steer (
      .clk     (clk),
      .rst_n   (rst_n),
      .levels  (levels),
      .routes  (routes),
      .irq_out (ctrl_irq)
   );
endmodule

// File: tb/pirq_router_test.sv
module pirq_router_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr_en = 1'b0;
   logic [7:0] cfg_addr = 8'h00;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       req_valid = 1'b0;
   logic [7:0] req_devfn = 8'h00;
   logic [1:0] req_pin = 2'd0;
   logic       req_level = 1'b0;
   logic [15:0] ctrl_irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pirq_router uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .req_valid(req_valid), .req_devfn(req_devfn), .req_pin(req_pin),
      .req_level(req_level), .ctrl_irq(ctrl_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic request(input int dev, input int pin, input logic lvl);
      req_devfn = {5'(dev), 3'd0}; req_pin = 2'(pin); req_level = lvl; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      chk("R4 outputs in reset", 32'(ctrl_irq), 0);
      rst_n = 1'b1;
      settle();
      chk("R4 outputs after reset", 32'(ctrl_irq), 0);
      for (int k = 0; k < 4; k++) begin
         cfg_read(8'(8'h60 + k), rd);
         chk("R4 steering reset value", 32'(rd), 32'h80);
      end

      // R3: read back and ignored offsets
      for (int k = 0; k < 4; k++) begin
         cfg_write(8'(8'h60 + k), 8'(8'h8C + k));
         cfg_read(8'(8'h60 + k), rd);
         chk("R3 readback bit7 kept", 32'(rd), 32'(8'h8C + k));
      end
      cfg_write(8'h64, 8'h05);
      cfg_write(8'h5F, 8'h06);
      cfg_read(8'h64, rd);
      chk("R3 other offset reads 0", 32'(rd), 0);
      cfg_read(8'h5F, rd);
      chk("R3 other offset reads 0", 32'(rd), 0);
      for (int k = 0; k < 4; k++) begin
         cfg_read(8'(8'h60 + k), rd);
         chk("R3 stray write ignored", 32'(rd), 32'(8'h8C + k));
      end

      // R1/R2: rotation sweep, line k steered to output k
      for (int k = 0; k < 4; k++) cfg_write(8'(8'h60 + k), 8'(k));
      for (int dev = 0; dev < 32; dev++) begin
         for (int pin = 0; pin < 4; pin++) begin
            int ln;
            ln = (pin + dev + 3) % 4;
            request(dev, pin, 1'b1);
            settle();
            if (dev == 0) chk("R2 device 0 wrap", 32'(ctrl_irq), 32'(1) << ln);
            else          chk("R1 pin rotation", 32'(ctrl_irq), 32'(1) << ln);
            request(1, ln, 1'b0);
            settle();
            chk("R8 level clear", 32'(ctrl_irq), 0);
         end
      end

      // R5: steering value sweep with line 0 active
      request(1, 0, 1'b1);
      for (int v = 0; v < 34; v++) begin
         logic [7:0] val;
         val = (v == 32) ? 8'h80 : (v == 33) ? 8'hFF : 8'(v);
         cfg_write(8'h60, val);
         settle();
         chk("R5 steering select", 32'(ctrl_irq), (val < 16) ? (32'(1) << val) : 0);
      end

      // R7: timing of a steering change without a new request
      cfg_write(8'h60, 8'd1);
      settle();
      chk("R7 initial route", 32'(ctrl_irq), 32'h2);
      cfg_write(8'h60, 8'd2);
      chk("R7 not before edge N+1", 32'(ctrl_irq), 32'h2);
      settle();
      chk("R7 moved after edge N+1", 32'(ctrl_irq), 32'h4);

      // R6/R8: sharing, lines 0,1,3 -> output 5, line 2 -> output 9
      cfg_write(8'h60, 8'd5);
      cfg_write(8'h61, 8'd5);
      cfg_write(8'h62, 8'd9);
      cfg_write(8'h63, 8'd5);
      for (int m = 0; m < 16; m++) begin
         logic [31:0] exp;
         for (int k = 0; k < 4; k++) request(1, k, m[k]);
         settle();
         exp = 0;
         if (m[0] || m[1] || m[3]) exp |= 32'h20;
         if (m[2]) exp |= 32'h200;
         chk("R6 wired OR sharing", 32'(ctrl_irq), exp);
      end
      // R8: clearing one line keeps the others
      for (int k = 0; k < 4; k++) request(1, k, 1'b1);
      request(1, 1, 1'b0);
      cfg_write(8'h60, 8'h80);
      settle();
      chk("R8 other lines kept", 32'(ctrl_irq), 32'h220);
      cfg_write(8'h63, 8'h90);
      settle();
      chk("R8 cleared line stays low", 32'(ctrl_irq), 32'h200);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule